// File: doc/BRIEF.md
# Single-Bit Manipulation Unit

This unit performs one bit-level operation per cycle on a byte operand for an 8-bit processor datapath. Each request carries an operand byte, a bit position, the current carry and zero flags and an operation code. The unit returns the resulting byte, the new carry and the new zero flag one clock later. The bit position comes from a 3-bit immediate or from the low bits of a register value.

The operations fall into three groups. Modifying operations change one bit of the byte and raise a write strobe so that the byte can be written back to its source. Transfer and logic operations fold the selected bit, or its complement, into carry. The test operation reports the complement of the selected bit on the zero flag. Instruction decode and memory access are handled elsewhere. For a memory operand, the caller reads the byte, presents it here, and uses the write strobe together with the returned byte to complete the read-modify-write.

Top module: `bitop_unit`

## Requirements
- R1: While rst_ni is low, all outputs are 0.
- R2: With idx_sel_reg_i=1, the bit position is idx_reg_i[2:0] and bits 7:3 of idx_reg_i have no effect. With idx_sel_reg_i=0, the position is idx_imm_i.
- R3: Opcode 0 sets, opcode 1 clears and opcode 2 inverts the selected bit. Every other bit is kept, and carry and zero are passed through unchanged.
- R4: Opcode 6 writes carry_i into the selected bit and opcode 7 writes ~carry_i into it. Carry and zero are passed through unchanged.
- R5: Opcode 4 loads the selected bit into carry and opcode 5 loads its complement. The byte and zero are passed through unchanged.
- R6: Opcodes 8/9 give carry = carry_i AND bit / AND ~bit. Opcodes 10/11 do the same with OR, and opcodes 12/13 with XOR. The byte and zero are passed through unchanged.
- R7: Opcode 3 sets zero to ~bit. The byte and carry are passed through unchanged.
- R8: A request with valid_i high at a rising edge produces its result on the outputs after that edge, with valid_o high for that one cycle. wr_en_o is high in that cycle only for opcodes 0, 1, 2, 6 and 7.
- R9: Opcodes 14 and 15 return the byte, carry and zero unchanged, with valid_o high and wr_en_o low.
- R10: After an edge with valid_i low, valid_o and wr_en_o are low and byte_o, carry_o and zero_o keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| op_i | input | 4 | Operation code |
| byte_i | input | 8 | Operand byte |
| idx_sel_reg_i | input | 1 | 1: position from register value, 0: from immediate |
| idx_imm_i | input | 3 | Immediate bit position |
| idx_reg_i | input | 8 | Register value whose low 3 bits give the position |
| carry_i | input | 1 | Current carry flag |
| zero_i | input | 1 | Current zero flag |
| valid_o | output | 1 | Result present |
| wr_en_o | output | 1 | Write back byte_o |
| byte_o | output | 8 | Resulting byte |
| carry_o | output | 1 | New carry |
| zero_o | output | 1 | New zero |

## Verification
Write-back and carry capture can coincide. A store operation writes the byte while carry must pass through untouched. The next request can also be accepted in the same cycle that a write-back result is presented. The bench provokes both by issuing every opcode back to back, at all eight positions and with both carry values, with random bytes, so a modifying result is immediately followed by a flag-only request. On every cycle, a behavioural model judges the byte, both flags and the strobe, which must drop on the cycle after a write.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SET  = 4'd0,
    OP_CLR  = 4'd1,
    OP_INV  = 4'd2,
    OP_TST  = 4'd3,
    OP_LD   = 4'd4,
    OP_LDN  = 4'd5,
    OP_ST   = 4'd6,
    OP_STN  = 4'd7,
    OP_AND  = 4'd8,
    OP_ANDN = 4'd9,
    OP_OR   = 4'd10,
    OP_ORN  = 4'd11,
    OP_XOR  = 4'd12,
    OP_XORN = 4'd13
  } bitop_op_e;

  typedef struct packed {
    logic wr;
    logic carry;
    logic zero;
  } bitop_flags_t;
endpackage

// File: rtl/bitop_index_sel.sv
module bitop_index_sel #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic              sel_reg_i,
  input  logic [IDX_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] reg_i,
  output logic [IDX_W-1:0]  idx_o
);
  // upper register bits are don't-care for the position
  logic unused_hi;
  assign unused_hi = ^reg_i[DATA_W-1:IDX_W];

  assign idx_o = sel_reg_i ? reg_i[IDX_W-1:0] : imm_i;
endmodule

// File: rtl/bitop_mask_dec.sv
module bitop_mask_dec #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] mask_o
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign mask_o[g] = (idx_i == IDX_W'(g));
  end
endmodule

// File: rtl/bitop_core.sv
module bitop_core
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic              carry_i,
  input  logic              zero_i,
  output logic [DATA_W-1:0] byte_o,
  output bitop_flags_t      flags_o
);
  logic      bit_sel;
  bitop_op_e op;

  assign bit_sel = |(byte_i & mask_i);
  assign op      = bitop_op_e'(op_i);

  always_comb begin
    byte_o        = byte_i;
    flags_o.wr    = 1'b0;
    flags_o.carry = carry_i;
    flags_o.zero  = zero_i;
    case (op)
      OP_SET:  begin byte_o = byte_i | mask_i;  flags_o.wr = 1'b1; end
      OP_CLR:  begin byte_o = byte_i & ~mask_i; flags_o.wr = 1'b1; end
      OP_INV:  begin byte_o = byte_i ^ mask_i;  flags_o.wr = 1'b1; end
      OP_ST:   begin
        byte_o     = carry_i ? (byte_i | mask_i) : (byte_i & ~mask_i);
        flags_o.wr = 1'b1;
      end
      OP_STN:  begin
        byte_o     = carry_i ? (byte_i & ~mask_i) : (byte_i | mask_i);
        flags_o.wr = 1'b1;
      end
      OP_TST:  flags_o.zero  = ~bit_sel;
      OP_LD:   flags_o.carry = bit_sel;
      OP_LDN:  flags_o.carry = ~bit_sel;
      OP_AND:  flags_o.carry = carry_i & bit_sel;
      OP_ANDN: flags_o.carry = carry_i & ~bit_sel;
      OP_OR:   flags_o.carry = carry_i | bit_sel;
      OP_ORN:  flags_o.carry = carry_i | ~bit_sel;
      OP_XOR:  flags_o.carry = carry_i ^ bit_sel;
      OP_XORN: flags_o.carry = carry_i ^ ~bit_sel;
      default: ;
    endcase
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              idx_sel_reg_i,
  input  logic [IDX_W-1:0]  idx_imm_i,
  input  logic [DATA_W-1:0] idx_reg_i,
  input  logic              carry_i,
  input  logic              zero_i,
  output logic              valid_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              carry_o,
  output logic              zero_o
);
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] byte_nx;
  bitop_flags_t      flags_nx;

  bitop_index_sel #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_idx (
    .sel_reg_i (idx_sel_reg_i),
    .imm_i     (idx_imm_i),
    .reg_i     (idx_reg_i),
    .idx_o     (idx)
  );

  bitop_mask_dec #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec (
    .idx_i  (idx),
    .mask_o (mask)
  );

  bitop_core #(.DATA_W(DATA_W)) u_core (
    .op_i    (op_i),
    .byte_i  (byte_i),
    .mask_i  (mask),
    .carry_i (carry_i),
    .zero_i  (zero_i),
    .byte_o  (byte_nx),
    .flags_o (flags_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      wr_en_o <= 1'b0;
      byte_o  <= '0;
      carry_o <= 1'b0;
      zero_o  <= 1'b0;
    end else if (valid_i) begin
      valid_o <= 1'b1;
      wr_en_o <= flags_nx.wr;
      byte_o  <= byte_nx;
      carry_o <= flags_nx.carry;
      zero_o  <= flags_nx.zero;
    end else begin
      valid_o <= 1'b0;
      wr_en_o <= 1'b0;
    end
  end

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && !wr_en_o);

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(byte_o) && $stable(carry_o) && $stable(zero_o));

  assert_single_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i <= 4'd2) |=> wr_en_o
      && ($countones(byte_o ^ $past(byte_i)) <= 1)
      && (carry_o == $past(carry_i)) && (zero_o == $past(zero_i)));

  assert_store_flags_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == 4'd6 || op_i == 4'd7) |=> wr_en_o
      && ($countones(byte_o ^ $past(byte_i)) <= 1)
      && (carry_o == $past(carry_i)) && (zero_o == $past(zero_i)));

  assert_test_keeps_carry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == 4'd3) |=> !wr_en_o
      && (byte_o == $past(byte_i)) && (carry_o == $past(carry_i)));

  assert_logic_no_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i >= 4'd8) && (op_i <= 4'd13) |=> !wr_en_o
      && (byte_o == $past(byte_i)) && (zero_o == $past(zero_i)));

  assert_unused_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i >= 4'd14) |=> valid_o && !wr_en_o
      && (byte_o == $past(byte_i)) && (carry_o == $past(carry_i))
      && (zero_o == $past(zero_i)));
endmodule

// File: tb/bitop_unit_test.sv
`timescale 1ns/1ps
module bitop_unit_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] byte_i = '0;
  logic       idx_sel_reg_i = 1'b0;
  logic [2:0] idx_imm_i = '0;
  logic [7:0] idx_reg_i = '0;
  logic       carry_i = 1'b0;
  logic       zero_i = 1'b0;
  logic       valid_o, wr_en_o, carry_o, zero_o;
  logic [7:0] byte_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] eb = '0;
  logic       ec = 1'b0, ez = 1'b0, ev = 1'b0, ew = 1'b0;

  always #2 clk_i = ~clk_i;

  bitop_unit uut (
    .clk_i, .rst_ni, .valid_i, .op_i, .byte_i, .idx_sel_reg_i, .idx_imm_i,
    .idx_reg_i, .carry_i, .zero_i, .valid_o, .wr_en_o, .byte_o, .carry_o, .zero_o
  );

  function automatic string tag_of(input logic [3:0] op);
    if (op <= 4'd2) return "R3";
    if (op == 4'd3) return "R7";
    if (op <= 4'd5) return "R5";
    if (op <= 4'd7) return "R4";
    if (op <= 4'd13) return "R6";
    return "R9";
  endfunction

  task automatic apply(input logic v, input logic [3:0] op, input logic [7:0] b,
                       input logic src, input logic [2:0] imm, input logic [7:0] rg,
                       input logic c, input logic z, input string tag);
    int  k;
    logic s;
    valid_i = v; op_i = op; byte_i = b; idx_sel_reg_i = src;
    idx_imm_i = imm; idx_reg_i = rg; carry_i = c; zero_i = z;
    if (v) begin
      k  = src ? int'(rg % 8) : int'(imm);
      s  = b[k];
      eb = b; ec = c; ez = z; ev = 1'b1; ew = 1'b0;
      case (op)
        4'd0:  begin eb[k] = 1'b1;  ew = 1'b1; end
        4'd1:  begin eb[k] = 1'b0;  ew = 1'b1; end
        4'd2:  begin eb[k] = !s;    ew = 1'b1; end
        4'd3:  ez = !s;
        4'd4:  ec = s;
        4'd5:  ec = !s;
        4'd6:  begin eb[k] = c;     ew = 1'b1; end
        4'd7:  begin eb[k] = !c;    ew = 1'b1; end
        4'd8:  ec = c && s;
        4'd9:  ec = c && !s;
        4'd10: ec = c || s;
        4'd11: ec = c || !s;
        4'd12: ec = c != s;
        4'd13: ec = c == s;
        default: ;
      endcase
    end else begin
      ev = 1'b0; ew = 1'b0;
    end
    @(negedge clk_i);
    n_vec++;
    if (byte_o !== eb || carry_o !== ec || zero_o !== ez) begin
      n_bad++;
      $display("FAIL %s op=%0d: got byte=%h c=%b z=%b, expected byte=%h c=%b z=%b",
               tag, op, byte_o, carry_o, zero_o, eb, ec, ez);
    end
    if (valid_o !== ev || wr_en_o !== ew) begin
      n_bad++;
      $display("FAIL R8 op=%0d: got valid=%b wr=%b, expected valid=%b wr=%b",
               op, valid_o, wr_en_o, ev, ew);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    n_vec++;
    if ({valid_o, wr_en_o, byte_o, carry_o, zero_o} !== 12'h0) begin
      n_bad++;
      $display("FAIL R1: got %h, expected 000",
               {valid_o, wr_en_o, byte_o, carry_o, zero_o});
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // every opcode, position and carry value, back to back
    for (int op = 0; op < 16; op++)
      for (int b = 0; b < 8; b++)
        for (int c = 0; c < 2; c++)
          for (int r = 0; r < 2; r++)
            apply(1'b1, 4'(op), 8'($urandom), 1'b0, 3'(b), 8'($urandom),
                  1'(c), 1'($urandom), tag_of(4'(op)));

    // register-sourced position with noisy upper bits (R2)
    for (int n = 0; n < 96; n++)
      apply(1'b1, 4'($urandom % 16), 8'($urandom), 1'b1, 3'($urandom),
            8'($urandom), 1'($urandom), 1'($urandom), "R2");

    // idle cycles after modifying results, inputs toggling (R10)
    for (int n = 0; n < 16; n++) begin
      apply(1'b1, 4'($urandom % 3), 8'($urandom), 1'b0, 3'($urandom),
            8'h00, 1'($urandom), 1'($urandom), "R3");
      apply(1'b0, 4'($urandom), 8'($urandom), 1'($urandom), 3'($urandom),
            8'($urandom), 1'($urandom), 1'($urandom), "R10");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule